// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block sits between a processor's address generator and memory and turns each 24-bit virtual address into a 32-bit physical address. The upper 11 bits of the virtual address select a page. The lower 13 bits are a byte offset that passes to the physical address unchanged. The mapping for each page sits in a flat table in memory, one 32-bit word per page. Software places that table by driving a base address and an entry count, and it reloads both whenever the running process changes.

For each request the block first checks the page number against the entry count. It then reads the entry word at base plus four times the page number and checks the entry's flags. Where the entry is accepted, it sets the entry's usage bits and writes the word back only if those bits changed. The requester gets one response beat that carries either the physical address or a fault code. When the paging-enable input is low, the virtual address is returned zero-extended, with no table access.

Top module: `vpage_xlate`

## Requirements
- R1: When `paging_en` is 0 at acceptance, the response is fault code 0 with `rsp_paddr` equal to the virtual address zero-extended to 32 bits. No memory access is made, and the response beat appears one cycle after the accepting edge.
- R2: With paging on, a page number (virtual bits 23..13) equal to or greater than `pt_len` gives fault code 3 and `rsp_paddr` of 0. No memory access is made, and the response beat appears one cycle after the accepting edge.
- R3: With paging on and the page in range, the block makes exactly one read, at address `pt_base + 4*page`.
- R4: A successful translation returns `rsp_paddr` with entry bits 31..13 in bits 31..13 and virtual bits 12..0 in bits 12..0, with fault code 0.
- R5: An entry whose valid flag (bit 0) is 0 gives fault code 1 and `rsp_paddr` 0. The entry is not written back.
- R6: A write request to a valid entry whose writable flag (bit 1) is 0 gives fault code 2 and `rsp_paddr` 0. The entry is not written back.
- R7: A successful access sets the referenced flag (bit 2), and a successful write also sets the dirty flag (bit 3). The entry is written back to the address it was read from, with every other bit kept, only when one of those two flags changed.
- R8: A table-backed response without write-back appears two cycles after the accepting edge, and one with write-back appears three cycles after it, given a memory that acknowledges in the same cycle.
- R9: One request is handled at a time. `req_ready` is low from the accepting edge until the response beat ends, and `rsp_valid` stays high for exactly one cycle.
- R10: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| paging_en | input | 1 | Translation on (1) or pass-through (0) |
| pt_base | input | 32 | Byte address of table entry 0 |
| pt_len | input | 12 | Number of entries in the table |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 24 | Virtual address |
| req_write | input | 1 | Request is a store |
| rsp_valid | output | 1 | Response beat |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 protection, 3 range |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Updated entry |
| mem_rdata | input | 32 | Entry read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access complete |

## Verification
Each result is due a fixed number of cycles after the edge that accepts a request. The bypass and range-fault responses are due one cycle later. Responses that read the table with no write-back, including the flag faults, are due two cycles later, and those with a write-back three cycles later. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the accepting edge until `rsp_valid` shows and compares that count with the figure the requirement gives. The bench memory model counts reads and writes and logs their addresses during each request, and these are checked against the expected access pattern. The stored entry is then compared with its old value plus only the flags that should have been set.

// File: rtl/vpx_pkg.sv
package vpx_pkg;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_INVALID = 2'd1,
      FLT_PROTECT = 2'd2,
      FLT_RANGE   = 2'd3
   } vpx_fault_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FETCH  = 2'd1,
      ST_UPDATE = 2'd2,
      ST_REPLY  = 2'd3
   } vpx_state_e;

   // flag positions inside a table entry (low nibble)
   localparam int unsigned FLAG_V = 0;
   localparam int unsigned FLAG_W = 1;
   localparam int unsigned FLAG_R = 2;
   localparam int unsigned FLAG_D = 3;
   localparam int unsigned FLAG_CNT = 4;

endpackage

// File: rtl/vpx_addr_gen.sv
module vpx_addr_gen #(
   parameter int unsigned PG_W  = 11,
   parameter int unsigned PA_W  = 32,
   parameter int unsigned LEN_W = PG_W + 1
) (
   input  logic [PG_W-1:0]  page,
   input  logic [PA_W-1:0]  base,
   input  logic [LEN_W-1:0] len,
   output logic             in_range,
   output logic [PA_W-1:0]  entry_addr
);
   localparam int unsigned PAD_W = LEN_W - PG_W;

   logic [LEN_W-1:0] page_ext;

   always_comb begin
      page_ext   = {{PAD_W{1'b0}}, page};
      in_range   = page_ext < len;
      entry_addr = base + (PA_W'(page) << 2);
   end
endmodule

// File: rtl/vpx_bypass.sv
module vpx_bypass #(
   parameter int unsigned VA_W = 24,
   parameter int unsigned PA_W = 32
) (
   input  logic [VA_W-1:0] vaddr,
   output logic [PA_W-1:0] paddr
);
   generate
      if (PA_W > VA_W) begin : g_widen
         assign paddr = {{(PA_W-VA_W){1'b0}}, vaddr};
      end else if (PA_W == VA_W) begin : g_same
         assign paddr = vaddr;
      end else begin : g_narrow
         logic [VA_W-PA_W-1:0] dropped;
         assign dropped = vaddr[VA_W-1:PA_W];
         assign paddr   = vaddr[PA_W-1:0] | {PA_W{1'b0 & (|dropped)}};
      end
   endgenerate
endmodule

// File: rtl/vpx_entry_eval.sv
module vpx_entry_eval
   import vpx_pkg::*;
#(
   parameter int unsigned ENT_W = 32,
   parameter int unsigned FRM_W = 19
) (
   input  logic [ENT_W-1:0] entry,
   input  logic             is_write,
   output logic [1:0]       fault,
   output logic [ENT_W-1:0] upd_entry,
   output logic             need_wb,
   output logic [FRM_W-1:0] frame
);
   always_comb begin
      frame             = entry[ENT_W-1 -: FRM_W];
      upd_entry         = entry;
      upd_entry[FLAG_R] = 1'b1;
      if (is_write) upd_entry[FLAG_D] = 1'b1;
      need_wb = (upd_entry != entry);
      if (!entry[FLAG_V])
         fault = FLT_INVALID;
      else if (is_write && !entry[FLAG_W])
         fault = FLT_PROTECT;
      else
         fault = FLT_NONE;
   end
endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate
   import vpx_pkg::*;
#(
   parameter int unsigned VA_W  = 24,
   parameter int unsigned PA_W  = 32,
   parameter int unsigned OFS_W = 13,
   parameter int unsigned ENT_W = 32,
   parameter int unsigned LEN_W = VA_W - OFS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              paging_en,
   input  logic [PA_W-1:0]   pt_base,
   input  logic [LEN_W-1:0]  pt_len,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic              req_write,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic [1:0]        rsp_fault,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PA_W-1:0]   mem_addr,
   output logic [ENT_W-1:0]  mem_wdata,
   input  logic [ENT_W-1:0]  mem_rdata,
   input  logic              mem_ack
);
   localparam int unsigned PG_W  = VA_W - OFS_W;
   localparam int unsigned FRM_W = PA_W - OFS_W;

   // elaboration checks on the parameter set
   generate
      if (OFS_W < 2 || OFS_W >= VA_W) begin : g_bad_ofs
         $error("vpage_xlate: offset width must be at least 2 and below VA_W");
      end
      if (ENT_W < FRM_W + FLAG_CNT) begin : g_bad_ent
         $error("vpage_xlate: entry too narrow for frame plus flags");
      end
      if (LEN_W < PG_W + 1) begin : g_bad_len
         $error("vpage_xlate: length register cannot cover every page");
      end
      if (PA_W <= OFS_W) begin : g_bad_pa
         $error("vpage_xlate: physical address has no frame bits");
      end
   endgenerate

   vpx_state_e        state_q;
   logic [VA_W-1:0]   vaddr_q;
   logic              write_q;
   logic [PA_W-1:0]   paddr_q;
   logic [1:0]        fault_q;
   logic [PA_W-1:0]   eaddr_q;
   logic [ENT_W-1:0]  wdata_q;

   logic              in_range;
   logic [PA_W-1:0]   entry_addr;
   logic [PA_W-1:0]   bypass_addr;
   logic [1:0]        ent_fault;
   logic [ENT_W-1:0]  upd_entry;
   logic              need_wb;
   logic [FRM_W-1:0]  frame;

   vpx_addr_gen #(
      .PG_W  (PG_W),
      .PA_W  (PA_W),
      .LEN_W (LEN_W)
   ) u_addr (
      .page       (req_vaddr[VA_W-1:OFS_W]),
      .base       (pt_base),
      .len        (pt_len),
      .in_range   (in_range),
      .entry_addr (entry_addr)
   );

   vpx_bypass #(
      .VA_W (VA_W),
      .PA_W (PA_W)
   ) u_bypass (
      .vaddr (req_vaddr),
      .paddr (bypass_addr)
   );

   vpx_entry_eval #(
      .ENT_W (ENT_W),
      .FRM_W (FRM_W)
   ) u_eval (
      .entry     (mem_rdata),
      .is_write  (write_q),
      .fault     (ent_fault),
      .upd_entry (upd_entry),
      .need_wb   (need_wb),
      .frame     (frame)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         vaddr_q <= '0;
         write_q <= 1'b0;
         paddr_q <= '0;
         fault_q <= FLT_NONE;
         eaddr_q <= '0;
         wdata_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  vaddr_q <= req_vaddr;
                  write_q <= req_write;
                  if (!paging_en) begin
                     paddr_q <= bypass_addr;
                     fault_q <= FLT_NONE;
                     state_q <= ST_REPLY;
                  end else if (!in_range) begin
                     paddr_q <= '0;
                     fault_q <= FLT_RANGE;
                     state_q <= ST_REPLY;
                  end else begin
                     eaddr_q <= entry_addr;
                     state_q <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  if (ent_fault != FLT_NONE) begin
                     paddr_q <= '0;
                     fault_q <= ent_fault;
                     state_q <= ST_REPLY;
                  end else begin
                     paddr_q <= {frame, vaddr_q[OFS_W-1:0]};
                     fault_q <= FLT_NONE;
                     if (need_wb) begin
                        wdata_q <= upd_entry;
                        state_q <= ST_UPDATE;
                     end else begin
                        state_q <= ST_REPLY;
                     end
                  end
               end
            end
            ST_UPDATE: begin
               if (mem_ack) state_q <= ST_REPLY;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   always_comb begin
      req_ready = (state_q == ST_IDLE);
      rsp_valid = (state_q == ST_REPLY);
      rsp_paddr = paddr_q;
      rsp_fault = fault_q;
      mem_req   = (state_q == ST_FETCH) || (state_q == ST_UPDATE);
      mem_we    = (state_q == ST_UPDATE);
      mem_addr  = eaddr_q;
      mem_wdata = wdata_q;
   end
endmodule

// File: rtl/vpx_checker.sv
module vpx_checker
   import vpx_pkg::*;
#(
   parameter int unsigned PA_W  = 32,
   parameter int unsigned ENT_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [PA_W-1:0]   rsp_paddr,
   input logic [1:0]        rsp_fault,
   input logic              mem_req,
   input logic              mem_we,
   input logic [PA_W-1:0]   mem_addr,
   input logic [ENT_W-1:0]  mem_wdata,
   input logic              mem_ack
);
   p_single_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_busy_on_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   p_idle_no_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req);

   p_fault_zero_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));

   p_hold_until_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   p_wb_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata[FLAG_R] && mem_wdata[FLAG_V]));

   p_wb_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && $past(mem_req && !mem_we)) |-> (mem_addr == $past(mem_addr)));
endmodule

bind vpage_xlate vpx_checker #(
   .PA_W  (PA_W),
   .ENT_W (ENT_W)
) u_vpx_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_paddr (rsp_paddr),
   .rsp_fault (rsp_fault),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack)
);

// File: tb/test_vpage_xlate.sv
`timescale 1ns/1ps
module test_vpage_xlate;
   localparam logic [31:0] ORG    = 32'h0000_4000;
   localparam logic [31:0] BASE_A = ORG;
   localparam logic [31:0] BASE_B = ORG + 32'd128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        paging_en = 1'b0;
   logic [31:0] pt_base = '0;
   logic [11:0] pt_len = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   logic [31:0] last_rd = '0;
   logic [31:0] last_wr = '0;
   logic [31:0] mem [64];

   always #2 clk = ~clk;

   vpage_xlate i_vpage_xlate (
      .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .pt_base(pt_base),
      .pt_len(pt_len), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_write(req_write), .rsp_valid(rsp_valid),
      .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   // memory model: acknowledges in the same cycle the request is seen
   initial begin
      forever begin
         @(negedge clk);
         mem_ack = mem_req;
         if (mem_req) begin
            int unsigned idx;
            idx = (mem_addr - ORG) >> 2;
            if (mem_we) begin
               if (idx < 64) mem[idx] = mem_wdata;
               wr_cnt++;
               last_wr = mem_addr;
            end else begin
               mem_rdata = (idx < 64) ? mem[idx] : 32'h0;
               rd_cnt++;
               last_rd = mem_addr;
            end
         end
      end
   end

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [18:0] frm, input logic [8:0] spare,
                                      input logic [3:0] flags);
      return {frm, spare, flags};
   endfunction

   // issue one request; returns response and latency in cycles after accept edge
   task automatic xlate(input logic [23:0] va, input logic wr,
                        output logic [31:0] pa, output logic [1:0] ft,
                        output int lat, output logic busy);
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0;
      req_vaddr = va; req_write = wr; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      busy = req_ready;
      lat = 1;
      while (!rsp_valid && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      pa = rsp_paddr;
      ft = rsp_fault;
   endtask

   task automatic run(input string tag, input logic [23:0] va, input logic wr,
                      input logic [31:0] exp_pa, input logic [1:0] exp_ft,
                      input int exp_lat, input int exp_rd, input int exp_wr);
      logic [31:0] pa; logic [1:0] ft; int lat; logic busy;
      xlate(va, wr, pa, ft, lat, busy);
      chk(tag, "paddr", 64'(pa), 64'(exp_pa));
      chk(tag, "fault", 64'(ft), 64'(exp_ft));
      chk(tag, "latency", 64'(lat), 64'(exp_lat));
      chk(tag, "reads", 64'(rd_cnt), 64'(exp_rd));
      chk(tag, "writes", 64'(wr_cnt), 64'(exp_wr));
      chk("R9", "ready low while busy", 64'(busy), 64'(0));
      @(negedge clk);
      chk("R9", "beat lasts one cycle", 64'(rsp_valid), 64'(0));
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      // table A (16 entries)
      mem[0]  = mk(19'h12345, 9'h000, 4'b0101);
      mem[1]  = mk(19'h00ABC, 9'h000, 4'b0001);
      mem[2]  = mk(19'h7FFFF, 9'h1A5, 4'b0111);
      mem[3]  = mk(19'h00042, 9'h000, 4'b1111);
      mem[4]  = mk(19'h11111, 9'h000, 4'b0110);
      mem[5]  = mk(19'h22222, 9'h000, 4'b0101);
      mem[15] = mk(19'h0F0F0, 9'h003, 4'b0001);
      mem[16] = mk(19'h33333, 9'h000, 4'b0101);
      // table B (24 entries at index 32)
      mem[32] = mk(19'h40001, 9'h000, 4'b0101);
      mem[55] = mk(19'h5ABCD, 9'h000, 4'b0011);
      mem[56] = mk(19'h66666, 9'h000, 4'b0101);

      repeat (3) @(negedge clk);
      chk("R10", "ready after reset", 64'(req_ready), 64'(1));
      chk("R10", "no response after reset", 64'(rsp_valid), 64'(0));
      chk("R10", "no memory request after reset", 64'(mem_req), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // R1: paging off, page beyond any length still passes through
      paging_en = 1'b0; pt_base = BASE_A; pt_len = 12'd16;
      run("R1", 24'hABCDEF, 1'b0, 32'h00ABCDEF, 2'd0, 1, 0, 0);
      run("R1", 24'h000001, 1'b1, 32'h00000001, 2'd0, 1, 0, 0);

      paging_en = 1'b1;
      // R2: page 16 is out of range for length 16
      run("R2", {11'd16, 13'h0000}, 1'b0, 32'h0, 2'd3, 1, 0, 0);

      // R4/R8: referenced already set, read -> no write-back
      run("R4", {11'd0, 13'h1ABC}, 1'b0, {19'h12345, 13'h1ABC}, 2'd0, 2, 1, 0);
      chk("R3", "entry address page 0", 64'(last_rd), 64'(BASE_A));
      chk("R7", "entry unchanged", 64'(mem[0]), 64'(mk(19'h12345, 9'h000, 4'b0101)));

      // R7/R8: read sets referenced -> write-back
      run("R7", {11'd1, 13'h0000}, 1'b0, {19'h00ABC, 13'h0000}, 2'd0, 3, 1, 1);
      chk("R3", "entry address page 1", 64'(last_rd), 64'(BASE_A + 32'd4));
      chk("R7", "wb address", 64'(last_wr), 64'(BASE_A + 32'd4));
      chk("R7", "referenced set", 64'(mem[1]), 64'(mk(19'h00ABC, 9'h000, 4'b0101)));

      // R7: write sets dirty, spare bits kept
      run("R7", {11'd2, 13'h1FFF}, 1'b1, {19'h7FFFF, 13'h1FFF}, 2'd0, 3, 1, 1);
      chk("R7", "dirty set, spare kept", 64'(mem[2]), 64'(mk(19'h7FFFF, 9'h1A5, 4'b1111)));

      // R8: write to already dirty entry -> no write-back
      run("R8", {11'd3, 13'h0010}, 1'b1, {19'h00042, 13'h0010}, 2'd0, 2, 1, 0);

      // R5: invalid entry
      run("R5", {11'd4, 13'h0004}, 1'b0, 32'h0, 2'd1, 2, 1, 0);
      chk("R5", "invalid entry untouched", 64'(mem[4]), 64'(mk(19'h11111, 9'h000, 4'b0110)));

      // R6: write to read-only entry
      run("R6", {11'd5, 13'h0008}, 1'b1, 32'h0, 2'd2, 2, 1, 0);
      chk("R6", "read-only entry untouched", 64'(mem[5]), 64'(mk(19'h22222, 9'h000, 4'b0101)));
      // R6: read of same entry succeeds
      run("R6", {11'd5, 13'h0008}, 1'b0, {19'h22222, 13'h0008}, 2'd0, 2, 1, 0);

      // R2: last page in range works
      run("R2", {11'd15, 13'h0123}, 1'b0, {19'h0F0F0, 13'h0123}, 2'd0, 3, 1, 1);
      chk("R7", "last entry referenced", 64'(mem[15]), 64'(mk(19'h0F0F0, 9'h003, 4'b0101)));

      // context switch: table B, 24 entries
      pt_base = BASE_B; pt_len = 12'd24;
      run("R3", {11'd0, 13'h0777}, 1'b0, {19'h40001, 13'h0777}, 2'd0, 2, 1, 0);
      chk("R3", "entry address table B page 0", 64'(last_rd), 64'(BASE_B));
      run("R7", {11'd23, 13'h0002}, 1'b1, {19'h5ABCD, 13'h0002}, 2'd0, 3, 1, 1);
      chk("R3", "entry address table B page 23", 64'(last_rd), 64'(BASE_B + 32'd92));
      chk("R7", "write sets both flags", 64'(mem[55]), 64'(mk(19'h5ABCD, 9'h000, 4'b1111)));
      run("R2", {11'd24, 13'h0000}, 1'b0, 32'h0, 2'd3, 1, 0, 0);
      chk("R2", "out-of-range entry untouched", 64'(mem[56]), 64'(mk(19'h66666, 9'h000, 4'b0101)));
      run("R2", {11'h7FF, 13'h1FFF}, 1'b1, 32'h0, 2'd3, 1, 0, 0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule